// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns one indexed-addressing postbyte, plus up to two extension bytes, into a 16-bit effective address. The caller supplies the four index registers (X, Y, SP and PC) and the two 8-bit accumulators, which together form the 16-bit D. It then pulses `start` with the postbyte. The block decodes the postbyte into one of seven modes and adds the right offset to the chosen base register. In the two memory-indirect modes it fetches a 16-bit pointer through a request/valid handshake and returns that pointer as the address.

Along with the address, the block reports four things: whether an index register has to be updated and with what value, how many extension bytes the mode consumed, whether the mode costs one extra cycle, and whether the mode is illegal under the `restricted` flag. Memory-to-memory moves raise that flag because they only permit the short forms. All results are registered and held until the next accepted `start`.

Top module: `idx_addr_gen`

## Requirements
- R1: With postbyte bit 5 = 0, the address is base + sign-extended bits 4:0. Bits 7:6 pick the base (0 = X, 1 = Y, 2 = SP, 3 = PC). No extension bytes and no extra cycle are reported, and `done` is high in the cycle after `start` is sampled.
- R2: With bit 5 = 1 and bits 7:6 not equal to 3, the mode is auto-adjust on the register named by bits 7:6. Bits 3:0 values 0..7 mean +1..+8 and values 8..15 mean -8..-1. `wb_en` = 1, `wb_sel` uses the R1 register code, and `wb_val` = old value + amount. No extension bytes and no extra cycle are reported.
- R3: In auto-adjust mode, bit 4 = 0 (pre) gives the adjusted value as the address, and bit 4 = 1 (post) gives the old value.
- R4: Postbyte 111rr00s gives a 9-bit signed offset {s, ext0} added to register rr. It reports 1 extension byte and no extra cycle.
- R5: Postbyte 111rr010 adds the 16-bit offset {ext0, ext1} (ext0 is the high byte) to register rr. It reports 2 extension bytes and 1 extra cycle.
- R6: Postbyte 111rr1aa with aa = 0, 1 or 2 adds unsigned A, unsigned B or D = {A, B} to register rr. It reports no extension bytes and no extra cycle.
- R7: Postbyte 111rr011 (register rr + {ext0, ext1}, 2 extension bytes) and postbyte 111rr111 (register rr + D, 0 extension bytes) read a 16-bit pointer at the sum. `mem_addr` equals the sum, the reported address is `mem_rdata`, and 1 extra cycle is reported.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is sampled high. `done` follows in the next cycle, and `mem_req` is then low.
- R9: With `restricted` = 1, the modes of R5 and R7 set `illegal`. They also give `eff_addr` = 0 and `wb_en` = 0, issue no memory request, and raise `done` in the cycle after `start`.
- R10: All address and write-back arithmetic wraps modulo 2^16.
- R11: After reset, `done`, `mem_req`, `wb_en` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a postbyte (ignored while a read is pending) |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext0 | input | 8 | First extension byte |
| ext1 | input | 8 | Second extension byte |
| restricted | input | 1 | Only short forms allowed |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Pointer read data |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective address |
| illegal | output | 1 | Mode not allowed under restricted |
| wb_en | output | 1 | Index register update required |
| wb_sel | output | 2 | Register to update (R1 code) |
| wb_val | output | 16 | New register value |
| ext_used | output | 2 | Extension bytes consumed |
| extra_cycle | output | 1 | Mode costs one extra cycle |

## Verification
The bench sweeps all 256 postbytes against two register sets. The first set is chosen so that large positive offsets wrap past 0xFFFF. The second sits near zero and has the accumulator top bits set, so a sign-extended accumulator or a non-wrapping adder would give a different address. A third sweep sets `restricted` and stalls the memory reply by two cycles. It separates legal short forms from rejected wide and indirect forms and shows that the request address holds during the stall. The pointer data is the request address XORed with a constant, which shows whether the returned address came from memory or from the sum.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [2:0] {
    M_SHORT, M_AUTO, M_OFS9, M_OFS16, M_IND16, M_ACC, M_IND_D
  } mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_FIN} seq_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] rsel;
    logic       pre;
    logic [1:0] acc;
    logic [1:0] ext_n;
    logic       xcyc;
    logic       rd;
    logic       wide;
  } dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_pkg::*;
(
  input  logic [7:0] pb,
  input  logic       restricted,
  output dec_t       dec,
  output logic       illegal
);
  always_comb begin
    dec      = '0;
    dec.mode = M_SHORT;
    dec.rsel = pb[7:6];
    dec.pre  = ~pb[4];
    dec.acc  = pb[1:0];
    if (!pb[5]) begin
      dec.mode = M_SHORT;
    end else if (pb[7:6] != 2'b11) begin
      dec.mode = M_AUTO;
    end else begin
      dec.rsel = pb[4:3];
      if (pb[2:0] == 3'b011) begin
        dec.mode  = M_IND16;
        dec.ext_n = 2'd2;
        dec.xcyc  = 1'b1;
        dec.rd    = 1'b1;
        dec.wide  = 1'b1;
      end else if (!pb[2]) begin
        if (pb[1]) begin
          dec.mode  = M_OFS16;
          dec.ext_n = 2'd2;
          dec.xcyc  = 1'b1;
          dec.wide  = 1'b1;
        end else begin
          dec.mode  = M_OFS9;
          dec.ext_n = 2'd1;
        end
      end else if (pb[1:0] == 2'b11) begin
        dec.mode = M_IND_D;
        dec.xcyc = 1'b1;
        dec.rd   = 1'b1;
      end else begin
        dec.mode = M_ACC;
      end
    end
    illegal = restricted & (dec.rd | dec.wide);
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW
) (
  input  dec_t          dec,
  input  logic [7:0]    pb,
  input  logic [BW-1:0] ext0,
  input  logic [BW-1:0] ext1,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val
);
  localparam int NREG = 4;

  logic [NREG-1:0][AW-1:0] bank;
  logic [AW-1:0] base, off, acc_off, adj;

  assign bank[0] = reg_x;
  assign bank[1] = reg_y;
  assign bank[2] = reg_sp;
  assign bank[3] = reg_pc;
  assign base    = bank[dec.rsel];

  always_comb begin
    case (dec.acc)
      2'd0:    acc_off = {{BW{1'b0}}, acc_a};
      2'd1:    acc_off = {{BW{1'b0}}, acc_b};
      default: acc_off = {acc_a, acc_b};
    endcase
  end

  always_comb begin
    case (dec.mode)
      M_SHORT: off = {{(AW-5){pb[4]}}, pb[4:0]};
      M_AUTO:  off = pb[3] ? {{(AW-4){1'b1}}, pb[3:0]}
                           : AW'(pb[2:0]) + AW'(1);
      M_OFS9:  off = {{(AW-BW-1){pb[0]}}, pb[0], ext0};
      M_OFS16, M_IND16: off = {ext0, ext1};
      default: off = acc_off;
    endcase
  end

  assign adj    = base + off;
  assign wb_val = adj;
  assign addr   = (dec.mode == M_AUTO && !dec.pre) ? base : adj;
endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_read,
  input  logic mem_valid,
  output logic accept,
  output logic ptr_load,
  output logic mem_req,
  output logic done
);
  seq_e st_q, st_d;

  assign accept   = start & (st_q != ST_READ);
  assign ptr_load = (st_q == ST_READ) & mem_valid;
  assign mem_req  = (st_q == ST_READ);
  assign done     = (st_q == ST_FIN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_READ: if (mem_valid) st_d = ST_FIN;
      default: begin
        if (accept) st_d = need_read ? ST_READ : ST_FIN;
        else        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R8: request held until a reply arrives
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req);
  // R8: completion one cycle after the reply
  a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> done && !mem_req);
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [BW-1:0] ext0,
  input  logic [BW-1:0] ext1,
  input  logic          restricted,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic [1:0]    ext_used,
  output logic          extra_cycle
);
  dec_t          dec;
  logic          ill_c, accept, ptr_load;
  logic [AW-1:0] addr_c, wbv_c;

  logic [AW-1:0] ea_q, ea_d, wbv_q, wbv_d;
  logic          ill_q, ill_d, wbe_q, wbe_d, xc_q, xc_d;
  logic [1:0]    sel_q, sel_d, ext_q, ext_d;

  idx_decode u_dec (
    .pb(postbyte), .restricted(restricted), .dec(dec), .illegal(ill_c)
  );

  idx_agen #(.BW(BW)) u_agen (
    .dec(dec), .pb(postbyte), .ext0(ext0), .ext1(ext1),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .addr(addr_c), .wb_val(wbv_c)
  );

  idx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .need_read(dec.rd & ~ill_c), .mem_valid(mem_valid),
    .accept(accept), .ptr_load(ptr_load), .mem_req(mem_req), .done(done)
  );

  always_comb begin
    ea_d  = ea_q;
    wbv_d = wbv_q;
    ill_d = ill_q;
    wbe_d = wbe_q;
    xc_d  = xc_q;
    sel_d = sel_q;
    ext_d = ext_q;
    if (accept) begin
      ea_d  = ill_c ? '0 : addr_c;
      wbv_d = wbv_c;
      ill_d = ill_c;
      wbe_d = (dec.mode == M_AUTO) & ~ill_c;
      sel_d = dec.rsel;
      ext_d = dec.ext_n;
      xc_d  = dec.xcyc;
    end else if (ptr_load) begin
      ea_d = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      wbv_q <= '0;
      ill_q <= 1'b0;
      wbe_q <= 1'b0;
      xc_q  <= 1'b0;
      sel_q <= '0;
      ext_q <= '0;
    end else begin
      ea_q  <= ea_d;
      wbv_q <= wbv_d;
      ill_q <= ill_d;
      wbe_q <= wbe_d;
      xc_q  <= xc_d;
      sel_q <= sel_d;
      ext_q <= ext_d;
    end
  end

  assign eff_addr    = ea_q;
  assign mem_addr    = ea_q;
  assign illegal     = ill_q;
  assign wb_en       = wbe_q;
  assign wb_sel      = sel_q;
  assign wb_val      = wbv_q;
  assign ext_used    = ext_q;
  assign extra_cycle = xc_q;

  // R8: address stable while waiting
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> $stable(mem_addr));
  // R9: rejected modes never update a register
  a_r9_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> !wb_en);
  // R2: auto-adjust never consumes extension bytes or extra cycles
  a_r2_wb_short: assert property (@(posedge clk) disable iff (!rst_n)
    done && wb_en |-> ext_used == 2'd0 && !extra_cycle);
  // R1: an accepted start yields a result or a request next cycle
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req |=> done || mem_req);
  // R9: an illegal result never came from a memory read
  a_r9_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !illegal);
endmodule

// File: tb/test_idx_addr_gen.sv
`timescale 1ns/1ps
module test_idx_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n, start, restricted, mem_valid;
  logic [7:0]  postbyte, ext0, ext1, acc_a, acc_b;
  logic [15:0] reg_x, reg_y, reg_sp, reg_pc, mem_rdata;
  logic        mem_req, done, illegal, wb_en, extra_cycle;
  logic [15:0] mem_addr, eff_addr, wb_val;
  logic [1:0]  wb_sel, ext_used;

  int total = 0;
  int bad   = 0;
  int stall = 0;
  localparam logic [15:0] KEY = 16'hA55A;

  always #2.5 clk = ~clk;

  idx_addr_gen i_idx_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .ext0(ext0), .ext1(ext1), .restricted(restricted),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done),
    .eff_addr(eff_addr), .illegal(illegal), .wb_en(wb_en), .wb_sel(wb_sel),
    .wb_val(wb_val), .ext_used(ext_used), .extra_cycle(extra_cycle)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] regval(input int code);
    case (code)
      0: return reg_x;
      1: return reg_y;
      2: return reg_sp;
      default: return reg_pc;
    endcase
  endfunction

  task automatic run(input logic [7:0] pb, input bit rs);
    int r, o, e_ext, waited;
    bit e_wb, e_pre, e_rd, e_xc, e_ill, saw_req, addr_moved;
    logic [15:0] sum, e_ea, e_wbv, first_addr;
    string tag;
    e_wb = 0; e_pre = 1; e_rd = 0; e_xc = 0; e_ext = 0; o = 0;
    if (pb[5] == 1'b0) begin
      r = pb[7:6]; tag = "R1";
      o = (pb[4:0] > 15) ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
    end else if (pb[7:6] != 2'b11) begin
      r = pb[7:6]; tag = pb[4] ? "R3" : "R2"; e_wb = 1; e_pre = !pb[4];
      o = (pb[3:0] < 8) ? int'(pb[3:0]) + 1 : int'(pb[3:0]) - 16;
    end else begin
      r = pb[4:3];
      if (pb[2:0] == 3'd3) begin
        tag = "R7"; o = {ext0, ext1}; e_ext = 2; e_xc = 1; e_rd = 1;
      end else if (pb[2] == 1'b0 && pb[1] == 1'b1) begin
        tag = "R5"; o = {ext0, ext1}; e_ext = 2; e_xc = 1;
      end else if (pb[2] == 1'b0) begin
        tag = "R4"; e_ext = 1;
        o = pb[0] ? int'(ext0) - 256 : int'(ext0);
      end else if (pb[1:0] == 2'd3) begin
        tag = "R7"; o = {acc_a, acc_b}; e_xc = 1; e_rd = 1;
      end else begin
        tag = "R6";
        o = (pb[1:0] == 2'd0) ? int'(acc_a) :
            (pb[1:0] == 2'd1) ? int'(acc_b) : int'({acc_a, acc_b});
      end
    end
    e_ill = rs && (e_rd || tag == "R5");
    if (e_ill) tag = "R9";
    sum   = 16'((int'(regval(r)) + o) & 32'hFFFF);
    e_wbv = sum;
    e_ea  = e_pre ? sum : regval(r);
    if (e_ill) e_ea = 16'h0;
    else if (e_rd) e_ea = sum ^ KEY;

    @(negedge clk);
    postbyte = pb; restricted = rs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0; saw_req = 0; addr_moved = 0; first_addr = mem_addr;
    while (!done && waited < 20) begin
      if (mem_req) begin
        if (!saw_req) first_addr = mem_addr;
        else if (mem_addr != first_addr) addr_moved = 1;
        saw_req = 1;
        if (waited >= stall) begin
          mem_valid = 1'b1; mem_rdata = mem_addr ^ KEY;
        end
      end
      @(negedge clk);
      waited++;
    end
    mem_valid = 1'b0;
    chk(done === 1'b1, {tag, " done"}, 32'(done), 32'd1);
    chk(eff_addr === e_ea, {tag, " eff_addr R10"}, 32'(eff_addr), 32'(e_ea));
    chk(saw_req == (e_rd && !e_ill), {tag, " R8 request"}, 32'(saw_req),
        32'(e_rd && !e_ill));
    if (saw_req) begin
      chk(first_addr === sum, {tag, " R7 mem_addr"}, 32'(first_addr), 32'(sum));
      chk(!addr_moved, {tag, " R8 addr stable"}, 32'(addr_moved), 32'd0);
      chk(mem_req === 1'b0, {tag, " R8 req drop"}, 32'(mem_req), 32'd0);
    end
    chk(illegal === e_ill, {tag, " illegal"}, 32'(illegal), 32'(e_ill));
    chk(wb_en === (e_wb && !e_ill), {tag, " wb_en"}, 32'(wb_en), 32'(e_wb));
    if (e_wb) begin
      chk(wb_sel === 2'(r), {tag, " wb_sel"}, 32'(wb_sel), 32'(r));
      chk(wb_val === e_wbv, {tag, " wb_val R10"}, 32'(wb_val), 32'(e_wbv));
    end
    chk(ext_used === 2'(e_ext), {tag, " ext_used"}, 32'(ext_used), 32'(e_ext));
    chk(extra_cycle === e_xc, {tag, " extra_cycle"}, 32'(extra_cycle), 32'(e_xc));
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; restricted = 1'b0; mem_valid = 1'b0;
    mem_rdata = '0; postbyte = '0; ext0 = '0; ext1 = '0;
    acc_a = '0; acc_b = '0; reg_x = '0; reg_y = '0; reg_sp = '0; reg_pc = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(done === 1'b0, "R11 done", 32'(done), 0);
    chk(mem_req === 1'b0, "R11 mem_req", 32'(mem_req), 0);
    chk(wb_en === 1'b0, "R11 wb_en", 32'(wb_en), 0);
    chk(illegal === 1'b0, "R11 illegal", 32'(illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // set 1: large values so wide offsets wrap
    reg_x = 16'h1234; reg_y = 16'hFFF0; reg_sp = 16'h0008; reg_pc = 16'h8000;
    acc_a = 8'hF3; acc_b = 8'h0C; ext0 = 8'hFE; ext1 = 8'h10;
    for (int p = 0; p < 256; p++) run(8'(p), 1'b0);

    // set 2: values near zero, accumulator top bits set
    reg_x = 16'h0000; reg_y = 16'h7FFF; reg_sp = 16'hFFFF; reg_pc = 16'h0002;
    acc_a = 8'h80; acc_b = 8'hFF; ext0 = 8'h01; ext1 = 8'h02;
    for (int p = 0; p < 256; p++) run(8'(p), 1'b0);

    // restricted with a stalled memory reply
    stall = 2;
    for (int p = 0; p < 256; p++) run(8'(p), 1'b1);
    for (int p = 0; p < 256; p++) run(8'(p), 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule